// File: doc/BRIEF.md
# Directory entry coherence controller

This block is the home-side controller for a directory-based cache coherence scheme. It keeps one directory entry for each tracked memory block. An entry holds a state (uncached, shared or exclusive) and a sharer vector with one bit per cache. Miss and write-back messages arrive from a requesting cache over a valid/ready handshake, at a rate of one per cycle.

For every accepted message the controller updates the entry. One cycle later it emits the matching actions: supply the data to the requester, pull the current copy from the owning cache, send invalidations to a mask of sharers, or tell the owner to drop its copy. A write-back that does not come from the current exclusive owner changes nothing and is reported as an error.

The network, the memory data path and the caches themselves sit outside this block.

Top module: `dir_coh_ctrl`

## Requirements
- R1: After reset every entry is uncached with an empty sharer vector, `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: A read miss (`req_op_i`=0) on an uncached entry returns data with no fetch and no invalidation. The sharer vector becomes the requester alone and the entry becomes shared.
- R3: A write miss (`req_op_i`=1) on an uncached entry returns data with no fetch and no invalidation. The requester becomes the sole exclusive owner.
- R4: A read miss on a shared entry returns data with no fetch, adds the requester to the sharer vector and leaves the entry shared.
- R5: A write miss on a shared entry returns data and drives `rsp_inval_o` to the old sharer vector with the requester's bit cleared (bit i is cache i). The requester becomes the sole exclusive owner.
- R6: A read miss on an exclusive entry from a non-owner returns data and asserts `rsp_fetch_o`, with `rsp_owner_o` set to the owner's index. The entry becomes shared by the owner and the requester.
- R7: A write miss on an exclusive entry from a non-owner returns data and asserts both `rsp_fetch_o` and `rsp_owner_inval_o`, with `rsp_owner_o` set to the owner's index. The requester becomes the new exclusive owner.
- R8: A write-back (`req_op_i`=2) from the exclusive owner makes the entry uncached with an empty sharer vector. It returns no data and flags no error.
- R9: A write-back on an entry that is not exclusive, a write-back from a cache that is not the owner, or an opcode of 3 asserts `rsp_error_o` with no other action and leaves the entry unchanged.
- R10: A miss from the cache that already owns an exclusive entry causes no fetch and no owner invalidation. The state and sharer updates still follow R6 and R7.
- R11: Each accepted request produces exactly one response, in the cycle after acceptance. Without an acceptance, `rsp_valid_o` is 0 in the next cycle. Back-to-back requests to the same block see each other's updates, and different blocks are independent. `rsp_owner_o` is 0 when `rsp_fetch_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller accepts a request |
| req_op_i | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_cache_i | input | $clog2(NUM_CACHES) | Requesting cache index |
| req_block_i | input | $clog2(NUM_BLOCKS) | Block index |
| rsp_valid_o | output | 1 | Response actions valid |
| rsp_return_o | output | 1 | Return data to requester |
| rsp_fetch_o | output | 1 | Fetch data from owner |
| rsp_owner_o | output | $clog2(NUM_CACHES) | Owner index for fetch |
| rsp_inval_o | output | NUM_CACHES | Sharers to invalidate |
| rsp_owner_inval_o | output | 1 | Owner must invalidate its copy |
| rsp_error_o | output | 1 | Request ignored as illegal |

## Verification
The bench builds the controller with NUM_CACHES=4 and NUM_BLOCKS=4. With four caches, a single block can hold three sharers at once, so the invalidation mask can be checked with several bits set and with the requester's bit removed. Every owner index is reachable, and owner changes can be chained across all caches. Four blocks make it possible to interleave traffic and show that an update to one entry leaves the others untouched.

// File: rtl/dir_coh_pkg.sv
package dir_coh_pkg;
  typedef enum logic [1:0] {
    ST_UNC = 2'd0,
    ST_SHR = 2'd1,
    ST_EXC = 2'd2
  } dir_state_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_WB  = 2'd2,
    OP_BAD = 2'd3
  } dir_op_e;
endpackage

// File: rtl/dir_store.sv
module dir_store
  import dir_coh_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int NUM_BLOCKS = 16,
  localparam int BW = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [BW-1:0]         rd_idx_i,
  output dir_state_e            rd_state_o,
  output logic [NUM_CACHES-1:0] rd_share_o,
  input  logic                  wr_en_i,
  input  logic [BW-1:0]         wr_idx_i,
  input  dir_state_e            wr_state_i,
  input  logic [NUM_CACHES-1:0] wr_share_i
);
  dir_state_e            state_q [NUM_BLOCKS];
  logic [NUM_CACHES-1:0] share_q [NUM_BLOCKS];

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        state_q[b] <= ST_UNC;
        share_q[b] <= '0;
      end else if (wr_en_i && (wr_idx_i == BW'(b))) begin
        state_q[b] <= wr_state_i;
        share_q[b] <= wr_share_i;
      end
    end
  end

  assign rd_state_o = state_q[rd_idx_i];
  assign rd_share_o = share_q[rd_idx_i];
endmodule

// File: rtl/dir_owner_enc.sv
module dir_owner_enc #(
  parameter int NUM_CACHES = 4,
  localparam int CW = $clog2(NUM_CACHES)
) (
  input  logic [NUM_CACHES-1:0] vec_i,
  output logic [CW-1:0]         idx_o
);
  // vector is one-hot in exclusive state; OR of set indices
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_CACHES; i++) begin
      if (vec_i[i]) idx_o = idx_o | CW'(i);
    end
  end
endmodule

// File: rtl/dir_next.sv
module dir_next
  import dir_coh_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  localparam int CW = $clog2(NUM_CACHES)
) (
  input  dir_op_e               op_i,
  input  logic [CW-1:0]         cache_i,
  input  dir_state_e            state_i,
  input  logic [NUM_CACHES-1:0] share_i,
  output logic                  upd_o,
  output dir_state_e            nxt_state_o,
  output logic [NUM_CACHES-1:0] nxt_share_o,
  output logic                  ret_o,
  output logic                  fetch_o,
  output logic [NUM_CACHES-1:0] inval_o,
  output logic                  oinv_o,
  output logic                  err_o
);
  logic [NUM_CACHES-1:0] c_mask;
  logic                  is_owner;

  assign c_mask   = {{(NUM_CACHES-1){1'b0}}, 1'b1} << cache_i;
  assign is_owner = share_i[cache_i];

  always_comb begin
    upd_o       = 1'b0;
    nxt_state_o = state_i;
    nxt_share_o = share_i;
    ret_o       = 1'b0;
    fetch_o     = 1'b0;
    inval_o     = '0;
    oinv_o      = 1'b0;
    err_o       = 1'b0;
    unique case (op_i)
      OP_RD: begin
        upd_o       = 1'b1;
        ret_o       = 1'b1;
        nxt_state_o = ST_SHR;
        if (state_i == ST_UNC) begin
          nxt_share_o = c_mask;
        end else begin
          nxt_share_o = share_i | c_mask;
          fetch_o     = (state_i == ST_EXC) && !is_owner;
        end
      end
      OP_WR: begin
        upd_o       = 1'b1;
        ret_o       = 1'b1;
        nxt_state_o = ST_EXC;
        nxt_share_o = c_mask;
        if (state_i == ST_SHR) inval_o = share_i & ~c_mask;
        if (state_i == ST_EXC) begin
          fetch_o = !is_owner;
          oinv_o  = !is_owner;
        end
      end
      OP_WB: begin
        if (state_i == ST_EXC && is_owner) begin
          upd_o       = 1'b1;
          nxt_state_o = ST_UNC;
          nxt_share_o = '0;
        end else begin
          err_o = 1'b1;
        end
      end
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dir_coh_ctrl.sv
module dir_coh_ctrl
  import dir_coh_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int NUM_BLOCKS = 16,
  localparam int CW = $clog2(NUM_CACHES),
  localparam int BW = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [1:0]            req_op_i,
  input  logic [CW-1:0]         req_cache_i,
  input  logic [BW-1:0]         req_block_i,
  output logic                  rsp_valid_o,
  output logic                  rsp_return_o,
  output logic                  rsp_fetch_o,
  output logic [CW-1:0]         rsp_owner_o,
  output logic [NUM_CACHES-1:0] rsp_inval_o,
  output logic                  rsp_owner_inval_o,
  output logic                  rsp_error_o
);
  dir_state_e            cur_state, nxt_state;
  logic [NUM_CACHES-1:0] cur_share, nxt_share, inval;
  logic [CW-1:0]         owner;
  logic                  upd, ret, fetch, oinv, err, accept, ready_q;

  assign req_ready_o = ready_q;
  assign accept      = req_valid_i && ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= 1'b1;
  end

  dir_store #(.NUM_CACHES(NUM_CACHES), .NUM_BLOCKS(NUM_BLOCKS)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (req_block_i),
    .rd_state_o (cur_state),
    .rd_share_o (cur_share),
    .wr_en_i    (accept && upd),
    .wr_idx_i   (req_block_i),
    .wr_state_i (nxt_state),
    .wr_share_i (nxt_share)
  );

  dir_next #(.NUM_CACHES(NUM_CACHES)) u_next (
    .op_i        (dir_op_e'(req_op_i)),
    .cache_i     (req_cache_i),
    .state_i     (cur_state),
    .share_i     (cur_share),
    .upd_o       (upd),
    .nxt_state_o (nxt_state),
    .nxt_share_o (nxt_share),
    .ret_o       (ret),
    .fetch_o     (fetch),
    .inval_o     (inval),
    .oinv_o      (oinv),
    .err_o       (err)
  );

  dir_owner_enc #(.NUM_CACHES(NUM_CACHES)) u_enc (
    .vec_i (cur_share),
    .idx_o (owner)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o       <= 1'b0;
      rsp_return_o      <= 1'b0;
      rsp_fetch_o       <= 1'b0;
      rsp_owner_o       <= '0;
      rsp_inval_o       <= '0;
      rsp_owner_inval_o <= 1'b0;
      rsp_error_o       <= 1'b0;
    end else begin
      rsp_valid_o       <= accept;
      rsp_return_o      <= accept && ret;
      rsp_fetch_o       <= accept && fetch;
      rsp_owner_o       <= (accept && fetch) ? owner : '0;
      rsp_inval_o       <= accept ? inval : '0;
      rsp_owner_inval_o <= accept && oinv;
      rsp_error_o       <= accept && err;
    end
  end
endmodule

// File: rtl/dir_coh_ctrl_chk.sv
module dir_coh_ctrl_chk #(
  parameter int NUM_CACHES = 4,
  parameter int NUM_BLOCKS = 16,
  localparam int CW = $clog2(NUM_CACHES),
  localparam int BW = $clog2(NUM_BLOCKS)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  req_ready_o,
  input logic [1:0]            req_op_i,
  input logic [CW-1:0]         req_cache_i,
  input logic [BW-1:0]         req_block_i,
  input logic                  rsp_valid_o,
  input logic                  rsp_return_o,
  input logic                  rsp_fetch_o,
  input logic [CW-1:0]         rsp_owner_o,
  input logic [NUM_CACHES-1:0] rsp_inval_o,
  input logic                  rsp_owner_inval_o,
  input logic                  rsp_error_o
);
  logic [CW-1:0] last_cache;
  logic [1:0]    last_op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_cache <= '0;
      last_op    <= '0;
    end else if (req_valid_i && req_ready_o) begin
      last_cache <= req_cache_i;
      last_op    <= req_op_i;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o); // R11
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !rsp_valid_o); // R11
  AST_FETCH_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fetch_o |-> (rsp_valid_o && rsp_return_o)); // R6
  AST_OINV_NEEDS_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_owner_inval_o |-> (rsp_fetch_o && last_op == 2'd1)); // R7
  AST_ERR_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_error_o |-> (!rsp_return_o && !rsp_fetch_o && rsp_inval_o == '0 && !rsp_owner_inval_o)); // R9
  AST_INVAL_SKIPS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !rsp_inval_o[last_cache]); // R5
  AST_NO_SELF_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fetch_o |-> (rsp_owner_o != last_cache)); // R10
  AST_WB_NO_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && last_op == 2'd2) |-> !rsp_return_o); // R8
endmodule

bind dir_coh_ctrl dir_coh_ctrl_chk #(.NUM_CACHES(NUM_CACHES), .NUM_BLOCKS(NUM_BLOCKS)) u_chk (.*);

// File: tb/dir_coh_ctrl_bench.sv
module dir_coh_ctrl_bench;
  localparam int N  = 4;
  localparam int B  = 4;
  localparam int CW = $clog2(N);
  localparam int BW = $clog2(B);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [CW-1:0] req_cache = '0;
  logic [BW-1:0] req_block = '0;
  logic          rsp_valid, rsp_return, rsp_fetch, rsp_oinv, rsp_error;
  logic [CW-1:0] rsp_owner;
  logic [N-1:0]  rsp_inval;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dir_coh_ctrl #(.NUM_CACHES(N), .NUM_BLOCKS(B)) u_dir_coh_ctrl (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .req_valid_i       (req_valid),
    .req_ready_o       (req_ready),
    .req_op_i          (req_op),
    .req_cache_i       (req_cache),
    .req_block_i       (req_block),
    .rsp_valid_o       (rsp_valid),
    .rsp_return_o      (rsp_return),
    .rsp_fetch_o       (rsp_fetch),
    .rsp_owner_o       (rsp_owner),
    .rsp_inval_o       (rsp_inval),
    .rsp_owner_inval_o (rsp_oinv),
    .rsp_error_o       (rsp_error)
  );

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, WB = 2'd2, BAD = 2'd3;

  // packed: valid,ret,fetch,owner[1:0],inval[3:0],oinv,err
  task automatic expect_rsp(input string tag, input logic ret, input logic fet,
                            input logic [CW-1:0] own, input logic [N-1:0] inv,
                            input logic oi, input logic er);
    logic [10:0] act, exp;
    act = {rsp_valid, rsp_return, rsp_fetch, rsp_owner, rsp_inval, rsp_oinv, rsp_error};
    exp = {1'b1, ret, fet, own, inv, oi, er};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input int c, input int b);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_cache = CW'(c);
    req_block = BW'(b);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    checks++;
    if (rsp_valid !== 1'b0) begin
      failures++;
      $display("FAIL %s act=%b exp=0", tag, rsp_valid);
    end
  endtask

  task automatic t_reset();
    #1;
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      failures++;
      $display("FAIL R1 act=%b%b exp=01", rsp_valid, req_ready);
    end
    send(RD, 1, 0); expect_rsp("R1 uncached start", 1, 0, 0, 4'b0000, 0, 0);
  endtask

  task automatic t_shared_build();
    send(RD, 2, 0); expect_rsp("R4 add sharer", 1, 0, 0, 4'b0000, 0, 0);
    send(RD, 3, 0); expect_rsp("R4 add sharer 3", 1, 0, 0, 4'b0000, 0, 0);
    send(WR, 2, 0); expect_rsp("R5 R2 inval mask", 1, 0, 0, 4'b1010, 0, 0);
  endtask

  task automatic t_exclusive();
    send(RD, 0, 0); expect_rsp("R6 fetch owner2", 1, 1, 2, 4'b0000, 0, 0);
    send(WR, 0, 0); expect_rsp("R6 shared pair", 1, 0, 0, 4'b0100, 0, 0);
    send(WR, 3, 0); expect_rsp("R7 owner change", 1, 1, 0, 4'b0000, 1, 0);
    send(RD, 3, 0); expect_rsp("R10 owner read", 1, 0, 0, 4'b0000, 0, 0);
    send(WR, 3, 0); expect_rsp("R10 shared self", 1, 0, 0, 4'b0000, 0, 0);
    send(WR, 3, 0); expect_rsp("R10 owner write", 1, 0, 0, 4'b0000, 0, 0);
  endtask

  task automatic t_writeback();
    send(WB, 1, 0); expect_rsp("R9 wb non-owner", 0, 0, 0, 4'b0000, 0, 1);
    send(RD, 0, 0); expect_rsp("R9 unchanged owner3", 1, 1, 3, 4'b0000, 0, 0);
    send(WB, 0, 0); expect_rsp("R9 wb shared", 0, 0, 0, 4'b0000, 0, 1);
    send(BAD, 0, 0); expect_rsp("R9 bad opcode", 0, 0, 0, 4'b0000, 0, 1);
    send(WR, 1, 0); expect_rsp("R9 set kept", 1, 0, 0, 4'b1001, 0, 0);
    send(WB, 1, 0); expect_rsp("R8 owner wb", 0, 0, 0, 4'b0000, 0, 0);
    send(RD, 2, 0); expect_rsp("R8 now uncached", 1, 0, 0, 4'b0000, 0, 0);
    send(WR, 0, 0); expect_rsp("R8 empty set", 1, 0, 0, 4'b0100, 0, 0);
    send(WB, 0, 0); expect_rsp("R8 wb again", 0, 0, 0, 4'b0000, 0, 0);
    send(WB, 0, 0); expect_rsp("R9 wb uncached", 0, 0, 0, 4'b0000, 0, 1);
  endtask

  task automatic t_blocks();
    send(WR, 0, 1); expect_rsp("R3 uncached write", 1, 0, 0, 4'b0000, 0, 0);
    send(RD, 1, 2); expect_rsp("R11 block2 fresh", 1, 0, 0, 4'b0000, 0, 0);
    send(WR, 2, 3); expect_rsp("R3 block3", 1, 0, 0, 4'b0000, 0, 0);
    send(RD, 1, 3); expect_rsp("R11 back-to-back", 1, 1, 2, 4'b0000, 0, 0);
    send(RD, 3, 1); expect_rsp("R3 owner0 block1", 1, 1, 0, 4'b0000, 0, 0);
    send(WR, 3, 2); expect_rsp("R11 block2 sharer", 1, 0, 0, 4'b0010, 0, 0);
    idle_check("R11 idle no rsp");
  endtask

  initial begin
    #10 rst_n = 1'b1;
    t_reset();
    t_shared_build();
    t_exclusive();
    t_writeback();
    t_blocks();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule